// File: doc/BRIEF.md
# Microprogrammed Control Sequencer for a Single-Bus Processor

This block is the control unit of a small load-store processor whose datapath hangs off one shared bus. A micro-program counter addresses a control store that is built into the block as a constant table. Each word of that store drives the datapath control pins directly: which register-file port is selected, register read and write strobes, load strobes for the memory-address, A, B and instruction registers, the ALU operation, and the bus-drive enables for the ALU and for memory read data. Each word also carries a two-bit next-address code that decides how the micro-program counter moves.

Every macro-instruction begins with the same five-step fetch routine. That routine reads PC into MA and A, writes A+4 back into PC, waits for memory, latches the instruction register and then dispatches on the opcode. Dispatch goes through an opcode-to-entry lookup into short routines for register-register ALU operations, load and register-indirect jump. Any opcode without a routine enters an illegal-instruction routine. That routine pulses an error flag and goes back to fetch. Memory is modelled only by a busy input. The datapath, the ALU arithmetic and the memory itself live outside the block.

Top module: `ucode_seq`

## Requirements
- R1: While rst_n is low, upc is 0 and every control output (reg_sel, reg_wr, reg_en, ma_ld, a_ld, b_ld, ir_ld, mem_en, alu_op, alu_en, illegal_op) is 0. Fetch resumes at micro-address 0 after release.
- R2: At micro-address 0 the block reads PC onto the bus and loads it into MA and A: reg_sel=0 (PC), reg_en=1, ma_ld=1, a_ld=1, all else 0. The next address is 1.
- R3: At micro-address 1 the ALU drives A+4 and PC is written: alu_op=5 (increment by 4), alu_en=1, reg_sel=0, reg_wr=1, all else 0.
- R4: A wait step (micro-address 2 in fetch, 26 in load) asserts no control. It holds upc for as long as mem_busy is sampled high at a clock edge, and it advances by one at the first edge where mem_busy is low.
- R5: At micro-address 3 memory data is put on the bus and loaded into IR: mem_en=1, ir_ld=1, all else 0.
- R6: Micro-address 4 asserts no control and dispatches on the opcode sampled at the edge. Opcode 0→8, 1→12, 2→16, 3→20, 8→24, 10→32, and every other value →60.
- R7: The register-register routine at base b (8, 12, 16 or 20) does three steps. At b it loads A from rs1 (reg_sel=1, reg_en, a_ld). At b+1 it loads B from rs2 (reg_sel=2, reg_en, b_ld). At b+2 it writes the ALU result to rd (reg_sel=3, reg_wr, alu_en) with alu_op 0 add, 1 sub, 2 and, 3 or respectively. It then goes to address 0.
- R8: The load routine does four steps. At 24 it loads A from rs1. At 25 the ALU passes A (alu_op=4, alu_en) into MA (ma_ld). At 26 it waits per R4. At 27 it writes memory data into rd (mem_en, reg_sel=3, reg_wr). It then goes to address 0.
- R9: The jump routine does two steps. At 32 it loads A from rs1. At 33 the ALU passes A into PC (alu_op=4, alu_en, reg_sel=0, reg_wr). It then goes to address 0.
- R10: At micro-address 60 illegal_op is 1 for exactly one cycle with all other controls 0, and upc is 0 on the next cycle.
- R11: In every cycle at most one of reg_en, alu_en and mem_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | OPC_W | Opcode field of the instruction register, used at dispatch |
| mem_busy | input | 1 | Memory not ready; holds a wait step |
| upc | output | UPC_W | Current micro-program counter |
| reg_sel | output | 2 | Register port select: 0 PC, 1 rs1, 2 rs2, 3 rd |
| reg_wr | output | 1 | Register-file write from the bus |
| reg_en | output | 1 | Register file drives the bus |
| ma_ld | output | 1 | Load memory-address register from the bus |
| a_ld | output | 1 | Load A from the bus |
| b_ld | output | 1 | Load B from the bus |
| ir_ld | output | 1 | Load instruction register from the bus |
| mem_en | output | 1 | Memory read data drives the bus |
| alu_op | output | 3 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 pass A, 5 A+4 |
| alu_en | output | 1 | ALU drives the bus |
| illegal_op | output | 1 | One-cycle pulse on an undispatched opcode |

## Verification
The bench builds the block with its defaults: a 6-bit micro-program counter and a 5-bit opcode. With those widths the random opcode stream can hit all 32 opcode values, so the bench reaches every mapped routine and a wide spread of unmapped codes that must land on the illegal routine. Random memory-busy runs stretch both wait steps over zero to many cycles. A reset applied in the middle of a routine shows that the sequencer goes quiet at once and then restarts from fetch.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  typedef enum logic [1:0] {NX_STEP, NX_DISP, NX_WAIT, NX_FETCH} nxt_e;
  typedef enum logic [1:0] {SEL_PC, SEL_RS1, SEL_RS2, SEL_RD} rsel_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_PASS, ALU_INC4} alu_e;

  typedef struct packed {
    rsel_e sel;
    logic  reg_wr;
    logic  reg_en;
    logic  ma_ld;
    logic  a_ld;
    logic  b_ld;
    logic  ir_ld;
    logic  mem_en;
    alu_e  alu;
    logic  alu_en;
    logic  err;
  } ctl_t;

  typedef struct packed {
    ctl_t ctl;
    nxt_e nxt;
  } uinst_t;

  // opcode values with a routine
  localparam int OPC_ADD  = 0;
  localparam int OPC_SUB  = 1;
  localparam int OPC_AND  = 2;
  localparam int OPC_OR   = 3;
  localparam int OPC_LOAD = 8;
  localparam int OPC_JUMP = 10;

  // micro-addresses
  localparam int UA_FETCH = 0;
  localparam int UA_WAITF = 2;
  localparam int UA_DISP  = 4;
  localparam int ENT_ADD  = 8;
  localparam int ENT_SUB  = 12;
  localparam int ENT_AND  = 16;
  localparam int ENT_OR   = 20;
  localparam int ENT_LOAD = 24;
  localparam int ENT_JUMP = 32;
  localparam int ENT_ILL  = 60;

  // a register drives the bus, optionally captured by MA, A or B
  function automatic uinst_t u_rd(rsel_e s, logic ma, logic a, logic b, nxt_e n);
    uinst_t w;
    w = '0;
    w.ctl.sel    = s;
    w.ctl.reg_en = 1'b1;
    w.ctl.ma_ld  = ma;
    w.ctl.a_ld   = a;
    w.ctl.b_ld   = b;
    w.nxt        = n;
    return w;
  endfunction

  // the ALU drives the bus, optionally into a register and/or MA
  function automatic uinst_t u_alu(alu_e op, logic wr, rsel_e s, logic ma, nxt_e n);
    uinst_t w;
    w = '0;
    w.ctl.alu    = op;
    w.ctl.alu_en = 1'b1;
    w.ctl.reg_wr = wr;
    w.ctl.sel    = s;
    w.ctl.ma_ld  = ma;
    w.nxt        = n;
    return w;
  endfunction

  // memory data drives the bus into IR or a register
  function automatic uinst_t u_mem(logic ir, logic wr, rsel_e s, nxt_e n);
    uinst_t w;
    w = '0;
    w.ctl.mem_en = 1'b1;
    w.ctl.ir_ld  = ir;
    w.ctl.reg_wr = wr;
    w.ctl.sel    = s;
    w.nxt        = n;
    return w;
  endfunction

  function automatic uinst_t u_seq(logic err, nxt_e n);
    uinst_t w;
    w = '0;
    w.ctl.err = err;
    w.nxt     = n;
    return w;
  endfunction

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_pkg::*;
#(
  parameter int UPC_W = 6
) (
  input  logic [UPC_W-1:0] addr,
  output uinst_t           word
);

  // three-step register-register routine at base b with ALU op op
  function automatic uinst_t rr_step(int off, alu_e op);
    uinst_t w;
    case (off)
      0:       w = u_rd(SEL_RS1, 1'b0, 1'b1, 1'b0, NX_STEP);
      1:       w = u_rd(SEL_RS2, 1'b0, 1'b0, 1'b1, NX_STEP);
      default: w = u_alu(op, 1'b1, SEL_RD, 1'b0, NX_FETCH);
    endcase
    return w;
  endfunction

  always_comb begin
    case (int'(addr))
      // common fetch
      0:  word = u_rd(SEL_PC, 1'b1, 1'b1, 1'b0, NX_STEP);
      1:  word = u_alu(ALU_INC4, 1'b1, SEL_PC, 1'b0, NX_STEP);
      2:  word = u_seq(1'b0, NX_WAIT);
      3:  word = u_mem(1'b1, 1'b0, SEL_PC, NX_STEP);
      4:  word = u_seq(1'b0, NX_DISP);
      // register-register group
      8, 9, 10:   word = rr_step(int'(addr) - ENT_ADD, ALU_ADD);
      12, 13, 14: word = rr_step(int'(addr) - ENT_SUB, ALU_SUB);
      16, 17, 18: word = rr_step(int'(addr) - ENT_AND, ALU_AND);
      20, 21, 22: word = rr_step(int'(addr) - ENT_OR, ALU_OR);
      // load
      24: word = u_rd(SEL_RS1, 1'b0, 1'b1, 1'b0, NX_STEP);
      25: word = u_alu(ALU_PASS, 1'b0, SEL_PC, 1'b1, NX_STEP);
      26: word = u_seq(1'b0, NX_WAIT);
      27: word = u_mem(1'b0, 1'b1, SEL_RD, NX_FETCH);
      // register-indirect jump
      32: word = u_rd(SEL_RS1, 1'b0, 1'b1, 1'b0, NX_STEP);
      33: word = u_alu(ALU_PASS, 1'b1, SEL_PC, 1'b0, NX_FETCH);
      // illegal opcode
      60: word = u_seq(1'b1, NX_FETCH);
      // unused words fall back to fetch with no controls
      default: word = u_seq(1'b0, NX_FETCH);
    endcase
  end

endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
  import ucode_pkg::*;
#(
  parameter int OPC_W = 5,
  parameter int UPC_W = 6
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [UPC_W-1:0] target
);

  always_comb begin
    case (int'(opcode))
      OPC_ADD:  target = UPC_W'(ENT_ADD);
      OPC_SUB:  target = UPC_W'(ENT_SUB);
      OPC_AND:  target = UPC_W'(ENT_AND);
      OPC_OR:   target = UPC_W'(ENT_OR);
      OPC_LOAD: target = UPC_W'(ENT_LOAD);
      OPC_JUMP: target = UPC_W'(ENT_JUMP);
      default:  target = UPC_W'(ENT_ILL);
    endcase
  end

endmodule

// File: rtl/ucode_upc.sv
module ucode_upc
  import ucode_pkg::*;
#(
  parameter int UPC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  nxt_e             nxt,
  input  logic [UPC_W-1:0] disp_tgt,
  input  logic             mem_busy,
  output logic [UPC_W-1:0] upc
);

  localparam logic [UPC_W-1:0] ONE  = UPC_W'(1);
  localparam logic [UPC_W-1:0] HOME = UPC_W'(UA_FETCH);

  logic [UPC_W-1:0] upc_nx;

  always_comb begin
    case (nxt)
      NX_STEP:  upc_nx = upc + ONE;
      NX_DISP:  upc_nx = disp_tgt;
      NX_WAIT:  upc_nx = mem_busy ? upc : upc + ONE;
      default:  upc_nx = HOME;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= HOME;
    else        upc <= upc_nx;
  end

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
#(
  parameter int UPC_W = 6,
  parameter int OPC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             mem_busy,
  output logic [UPC_W-1:0] upc,
  output logic [1:0]       reg_sel,
  output logic             reg_wr,
  output logic             reg_en,
  output logic             ma_ld,
  output logic             a_ld,
  output logic             b_ld,
  output logic             ir_ld,
  output logic             mem_en,
  output logic [2:0]       alu_op,
  output logic             alu_en,
  output logic             illegal_op
);

  uinst_t           word;
  ctl_t             ctl;
  logic [UPC_W-1:0] disp_tgt;

  ucode_rom #(.UPC_W(UPC_W)) u_rom (
    .addr (upc),
    .word (word)
  );

  ucode_dispatch #(.OPC_W(OPC_W), .UPC_W(UPC_W)) u_disp (
    .opcode (opcode),
    .target (disp_tgt)
  );

  ucode_upc #(.UPC_W(UPC_W)) u_upc (
    .clk      (clk),
    .rst_n    (rst_n),
    .nxt      (word.nxt),
    .disp_tgt (disp_tgt),
    .mem_busy (mem_busy),
    .upc      (upc)
  );

  // all strobes are forced quiet for the whole time reset is held
  assign ctl = rst_n ? word.ctl : '0;

  assign reg_sel    = ctl.sel;
  assign reg_wr     = ctl.reg_wr;
  assign reg_en     = ctl.reg_en;
  assign ma_ld      = ctl.ma_ld;
  assign a_ld       = ctl.a_ld;
  assign b_ld       = ctl.b_ld;
  assign ir_ld      = ctl.ir_ld;
  assign mem_en     = ctl.mem_en;
  assign alu_op     = ctl.alu;
  assign alu_en     = ctl.alu_en;
  assign illegal_op = ctl.err;

endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk
  import ucode_pkg::*;
#(
  parameter int UPC_W = 6,
  parameter int OPC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OPC_W-1:0] opcode,
  input logic             mem_busy,
  input logic [UPC_W-1:0] upc,
  input logic [1:0]       reg_sel,
  input logic             reg_wr,
  input logic             reg_en,
  input logic             ma_ld,
  input logic             a_ld,
  input logic             b_ld,
  input logic             ir_ld,
  input logic             mem_en,
  input logic [2:0]       alu_op,
  input logic             alu_en,
  input logic             illegal_op
);

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!reg_wr && !reg_en && !ma_ld && !a_ld && !b_ld &&
                               !ir_ld && !mem_en && !alu_en && !illegal_op);
    end
  end

  // R11
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_en, alu_en, mem_en}));

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UPC_W'(UA_WAITF) && mem_busy) |=> (upc == UPC_W'(UA_WAITF)));

  // R6
  disp_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UPC_W'(UA_DISP) && opcode == OPC_W'(OPC_ADD)) |=> (upc == UPC_W'(ENT_ADD)));

  // R10
  illegal_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> (upc == UPC_W'(UA_FETCH) && !illegal_op));

  // R2
  fetch_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upc == UPC_W'(UA_FETCH)) |-> (reg_en && ma_ld && a_ld && reg_sel == 2'd0 && !reg_wr));

endmodule

bind ucode_seq ucode_seq_chk #(.UPC_W(UPC_W), .OPC_W(OPC_W)) u_chk (.*);

// File: tb/ucode_seq_bench.sv
module ucode_seq_bench;

  localparam int UPC_W = 6;
  localparam int OPC_W = 5;
  localparam int RUN   = 3200;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [OPC_W-1:0] opcode = '0;
  logic             mem_busy = 1'b0;
  logic [UPC_W-1:0] upc;
  logic [1:0]       reg_sel;
  logic             reg_wr, reg_en, ma_ld, a_ld, b_ld, ir_ld, mem_en, alu_en, illegal_op;
  logic [2:0]       alu_op;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_u  = 0;
  int prev_u = 0;
  bit done   = 1'b0;

  ucode_seq #(.UPC_W(UPC_W), .OPC_W(OPC_W)) u_ucode_seq (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .mem_busy(mem_busy), .upc(upc),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_en(reg_en), .ma_ld(ma_ld), .a_ld(a_ld),
    .b_ld(b_ld), .ir_ld(ir_ld), .mem_en(mem_en), .alu_op(alu_op), .alu_en(alu_en),
    .illegal_op(illegal_op)
  );

  always #5 clk = ~clk;

  // packed {sel, wr, en, ma, a, b, ir, mem, alu, alu_en, err}
  function automatic logic [13:0] mk(int sel, bit wr, bit en, bit ma, bit a, bit b,
                                     bit ir, bit mem, int alu, bit aen, bit err);
    return {2'(sel), wr, en, ma, a, b, ir, mem, 3'(alu), aen, err};
  endfunction

  function automatic logic [13:0] exp_ctl(int u);
    case (u)
      0:  return mk(0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0);
      1:  return mk(0, 1, 0, 0, 0, 0, 0, 0, 5, 1, 0);
      3:  return mk(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
      8, 12, 16, 20, 24, 32: return mk(1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0);
      9, 13, 17, 21: return mk(2, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0);
      10, 14, 18, 22: return mk(3, 1, 0, 0, 0, 0, 0, 0, (u - 10) / 4, 1, 0);
      25: return mk(0, 0, 0, 1, 0, 0, 0, 0, 4, 1, 0);
      27: return mk(3, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0);
      33: return mk(0, 1, 0, 0, 0, 0, 0, 0, 4, 1, 0);
      60: return mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      default: return '0;
    endcase
  endfunction

  function automatic int disp_of(int opc);
    case (opc)
      0: return 8;
      1: return 12;
      2: return 16;
      3: return 20;
      8: return 24;
      10: return 32;
      default: return 60;
    endcase
  endfunction

  function automatic int exp_next(int u, int opc, bit busy);
    case (u)
      2, 26: return busy ? u : u + 1;
      4: return disp_of(opc);
      10, 14, 18, 22, 27, 33, 60: return 0;
      default: return u + 1;
    endcase
  endfunction

  function automatic string req_of(int u);
    if (u == 0) return "R2";
    if (u == 1) return "R3";
    if (u == 2) return "R4";
    if (u == 3) return "R5";
    if (u == 4) return "R6";
    if (u >= 8 && u <= 22) return "R7";
    if (u >= 24 && u <= 27) return "R8";
    if (u == 32 || u == 33) return "R9";
    return "R10";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // reference micro-PC, same reset style as the block
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_u <= 0;
    else        exp_u <= exp_next(exp_u, int'(opcode), mem_busy);
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [13:0] act;
      act = {reg_sel, reg_wr, reg_en, ma_ld, a_ld, b_ld, ir_ld, mem_en, alu_op, alu_en, illegal_op};
      if (!rst_n) begin
        // R1: quiet and at address 0 while reset is held
        check(act == '0, "R1", "controls in reset", int'(act), 0);
        check(upc == '0, "R1", "upc in reset", int'(upc), 0);
      end else begin
        check(int'(upc) == exp_u,
              (prev_u == 4) ? "R6" : (prev_u == 2 || prev_u == 26) ? "R4" : req_of(exp_u),
              "upc", int'(upc), exp_u);
        check(act == exp_ctl(exp_u), req_of(exp_u), "controls", int'(act), int'(exp_ctl(exp_u)));
        // R11: single bus driver
        check(32'(reg_en) + 32'(alu_en) + 32'(mem_en) <= 1, "R11", "bus drivers",
              int'({reg_en, alu_en, mem_en}), 0);
      end
      prev_u = exp_u;
      // drive next inputs
      cyc++;
      rst_n = !(cyc < 3 || (cyc >= 1500 && cyc < 1503));
      if (cyc < 60) begin
        // directed: long memory stall, then legal opcodes in turn
        mem_busy = (cyc % 20) < 12;
        opcode   = OPC_W'((cyc / 12) % 2 == 0 ? 8 : 10);
      end else begin
        mem_busy = ($urandom_range(0, 99) < 45);
        if ($urandom_range(0, 3) == 0) opcode = OPC_W'($urandom_range(0, 31));
        else begin
          case ($urandom_range(0, 5))
            0: opcode = 5'd0;
            1: opcode = 5'd1;
            2: opcode = 5'd2;
            3: opcode = 5'd3;
            4: opcode = 5'd8;
            default: opcode = 5'd10;
          endcase
        end
      end
      if (cyc >= RUN) begin
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #(100_000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule